// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier (8 x 8)

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. Each partial-product row is the multiplicand ANDed with one bit of the multiplier and shifted by that bit's position. There is no recoding. The eight rows are reduced to two by two levels of 4-to-2 compressor rows. A ripple chain of full adders then adds the last two rows. The result is held in an output register stage.

Each compressor cell adds four data bits and an incoming side carry. It returns a sum bit in its own column and two bits one column higher: a vertical carry and a side carry-out. The side carry-out is formed from the four data bits alone and never from the incoming side carry. So a cell's side carry feeds the next-higher cell in the same row without any ripple along that row. Any carry leaving bit 15 is discarded, because an 8 x 8 unsigned product always fits in 16 bits.

Top module: `ctree_mul`

## Requirements
- R1: For every pair of 8-bit unsigned operands, the registered product equals their arithmetic product as a 16-bit unsigned value.
- R2: Each compressor cell satisfies d1+d2+d3+d4+side_in = sum + 2*(carry + side_out) for all 32 input combinations.
- R3: The cell sum output equals the XOR of all five of its inputs.
- R4: The cell side_out is 1 when three or more data inputs are high, and 0 when at most one data input is high. It has the same value for side_in=0 and side_in=1 with the data inputs held.
- R5: When all four data inputs of a cell are high, carry and side_out are both 1.
- R6: Partial products are the plain AND of operand bits. A zero operand gives a zero product. An operand of the form 2^k scales the other operand by a left shift of k.
- R7: `prod_o` updates one rising clock edge after the operands are presented. It does not change between edges when the operands change.
- R8: Driving `rst_n` low clears `prod_o` to 0 at once, without waiting for a clock edge. It stays 0 while reset is held.
- R9: The largest operands 255 x 255 give 65025 with no bit lost, even though carries above bit 15 are dropped inside the tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned; bit r selects partial-product row r |
| prod_o | output | 16 | Registered unsigned product |

## Verification
The whole block is swept over every one of the 65,536 operand pairs. The sweep covers the general case, so no row or column of the tree can hide a wrong wire. Zero operands, one-hot operands and the all-ones pair are called out on their own. They separate a broken AND gating, a misplaced shift and a carry lost at the top column. A separate test drives one compressor cell through all 32 input codes. It checks the weight equation and the sum parity. It also compares side_out with side_in at 0 and at 1, which is how a cell whose side carry listens to side_in is caught. A mid-cycle reset and a mid-cycle operand change show whether the output register is asynchronous and edge-driven.

// File: rtl/ctree_pkg.sv
package ctree_pkg;
    // Number of partial-product rows the two-level 4:2 tree accepts.
    localparam int TREE_ROWS = 8;
    // Rows consumed by one compressor row.
    localparam int ROWS_PER_CMP = 4;
endpackage

// File: rtl/cmp42_cell.sv
// One 4:2 compressor cell.
// sum sits at column weight 1. carry and side_out sit at weight 2.
// side_out is formed from d1..d4 only, so it never waits on side_in.
module cmp42_cell (
    input  logic d1,
    input  logic d2,
    input  logic d3,
    input  logic d4,
    input  logic side_in,
    output logic sum,
    output logic carry,
    output logic side_out
);
    logic p3;

    always_comb begin
        p3       = d1 ^ d2 ^ d3;
        side_out = (d1 & d2) | (d1 & d3) | (d2 & d3);
        sum      = p3 ^ d4 ^ side_in;
        carry    = (p3 & d4) | (p3 & side_in) | (d4 & side_in);
    end

    logic [2:0] n_data;
    always_comb begin
        n_data = 3'(d1) + 3'(d2) + 3'(d3) + 3'(d4);
        if (!$isunknown({d1, d2, d3, d4, side_in})) begin
            assert_weight_R2: assert ((n_data + 3'(side_in)) ==
                                      (3'(sum) + 3'(2) * (3'(carry) + 3'(side_out))))
                else $error("cell weight equation broken");
            assert_parity_R3: assert (sum == ^{d1, d2, d3, d4, side_in})
                else $error("cell sum parity broken");
            assert_side_out_R4: assert (!(n_data >= 3'd3) || side_out)
                else $error("side_out low with three or more data bits high");
            assert_side_low_R4: assert (!(n_data <= 3'd1) || !side_out)
                else $error("side_out high with at most one data bit high");
            assert_all_high_R5: assert (!(n_data == 3'd4) || (carry && side_out))
                else $error("four data bits high without both carries");
        end
    end
endmodule

// File: rtl/cmp42_row.sv
// A row of 4:2 cells across W columns: four W-bit words in, two words out.
// Each cell's side_out feeds the side_in of the cell one column up.
module cmp42_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] w0_i,
    input  logic [W-1:0] w1_i,
    input  logic [W-1:0] w2_i,
    input  logic [W-1:0] w3_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o
);
    logic [W-1:0] s_col;
    logic [W-1:0] c_col;
    logic [W-1:0] so_col;
    logic [W-1:0] si_col;

    assign si_col = {so_col[W-2:0], 1'b0};

    for (genvar k = 0; k < W; k++) begin : g_col
        cmp42_cell cell_i (
            .d1      (w0_i[k]),
            .d2      (w1_i[k]),
            .d3      (w2_i[k]),
            .d4      (w3_i[k]),
            .side_in (si_col[k]),
            .sum     (s_col[k]),
            .carry   (c_col[k]),
            .side_out(so_col[k])
        );
    end

    assign sum_o = s_col;
    assign car_o = {c_col[W-2:0], 1'b0};

    // R1: the row keeps the total exactly, counting what leaves the top column.
    always_comb begin
        if (!$isunknown({w0_i, w1_i, w2_i, w3_i})) begin
            assert_row_total_R1: assert (
                ((W+3)'(w0_i) + (W+3)'(w1_i) + (W+3)'(w2_i) + (W+3)'(w3_i)) ==
                ((W+3)'(sum_o) + (W+3)'(car_o) +
                 (((W+3)'(c_col[W-1]) + (W+3)'(so_col[W-1])) << W)))
                else $error("compressor row lost weight");
        end
    end
endmodule

// File: rtl/rca_add.sv
// Ripple chain of full adders. The carry out of the top bit is dropped.
module rca_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_fa
        assign s_o[k]  = x_i[k] ^ y_i[k] ^ cy[k];
        assign cy[k+1] = (x_i[k] & y_i[k]) | (x_i[k] & cy[k]) | (y_i[k] & cy[k]);
    end

    // R1: the adder is exact when the carry out is included.
    always_comb begin
        if (!$isunknown({x_i, y_i})) begin
            assert_adder_R1: assert (((W+1)'(x_i) + (W+1)'(y_i)) == {cy[W], s_o})
                else $error("final adder sum wrong");
        end
    end
endmodule

// File: rtl/ctree_mul.sv
// Unsigned multiplier: AND partial products, two levels of 4:2 rows,
// ripple final adder, then an output register.
module ctree_mul #(
    parameter int WIDTH   = 8,   // operand width, 5..8 (the tree holds 8 rows)
    parameter bit REG_OUT = 1'b1 // 1: registered product, 0: combinational
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0] prod_o
);
    import ctree_pkg::*;

    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [PW-1:0] prod;
    } out_t;

    // Partial products; rows past WIDTH are padded with zeros.
    logic [PW-1:0] pp [TREE_ROWS];
    for (genvar r = 0; r < TREE_ROWS; r++) begin : g_pp
        if (r < WIDTH) begin : g_live
            assign pp[r] = PW'(a_i & {WIDTH{b_i[r]}}) << r;
        end else begin : g_pad
            assign pp[r] = '0;
        end
    end

    // Level 1: two compressor rows, 8 -> 4 words.
    logic [PW-1:0] l1_s [2];
    logic [PW-1:0] l1_c [2];
    for (genvar g = 0; g < 2; g++) begin : g_lvl1
        cmp42_row #(.W(PW)) row_i (
            .w0_i (pp[ROWS_PER_CMP*g + 0]),
            .w1_i (pp[ROWS_PER_CMP*g + 1]),
            .w2_i (pp[ROWS_PER_CMP*g + 2]),
            .w3_i (pp[ROWS_PER_CMP*g + 3]),
            .sum_o(l1_s[g]),
            .car_o(l1_c[g])
        );
    end

    // Level 2: one compressor row, 4 -> 2 words.
    logic [PW-1:0] l2_s;
    logic [PW-1:0] l2_c;
    cmp42_row #(.W(PW)) row2_i (
        .w0_i (l1_s[0]),
        .w1_i (l1_c[0]),
        .w2_i (l1_s[1]),
        .w3_i (l1_c[1]),
        .sum_o(l2_s),
        .car_o(l2_c)
    );

    logic [PW-1:0] total;
    rca_add #(.W(PW)) add_i (
        .x_i(l2_s),
        .y_i(l2_c),
        .s_o(total)
    );

    out_t out_d;
    always_comb begin
        out_d      = '0;
        out_d.prod = total;
    end

    if (REG_OUT) begin : g_reg
        out_t out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign prod_o = out_q.prod;

        assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod_o == PW'($past(a_i)) * PW'($past(b_i))))
            else $error("registered product does not match previous operands");

        assert_reset_R8: assert property (@(posedge clk)
            !rst_n |=> (prod_o == '0))
            else $error("product not cleared by reset");
    end else begin : g_comb
        assign prod_o = out_d.prod;
    end
endmodule

// File: tb/ctree_mul_tb_top.sv
module ctree_mul_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [PW-1:0] prod_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctree_mul #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_i),
        .b_i   (b_i),
        .prod_o(prod_o)
    );

    // Stand-alone compressor cell for the unit test.
    logic c_d1 = 1'b0, c_d2 = 1'b0, c_d3 = 1'b0, c_d4 = 1'b0, c_si = 1'b0;
    logic c_sum, c_car, c_so;
    cmp42_cell cell_i (
        .d1(c_d1), .d2(c_d2), .d3(c_d3), .d4(c_d4), .side_in(c_si),
        .sum(c_sum), .carry(c_car), .side_out(c_so)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Apply operands at a falling edge, then return at the next falling edge.
    task automatic apply(input int a, input int b);
        a_i = W'(a);
        b_i = W'(b);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // ---- compressor cell unit test: R2 R3 R4 R5 ----
        for (int code = 0; code < 16; code++) begin
            int nd;
            int so0;
            nd = code[0] + code[1] + code[2] + code[3];
            {c_d4, c_d3, c_d2, c_d1} = code[3:0];
            c_si = 1'b0;
            #1;
            so0 = c_so;
            check("R2", c_sum + 2 * (c_car + c_so), nd);
            check("R3", c_sum, nd % 2);
            if (nd >= 3) check("R4", c_so, 1);
            if (nd <= 1) check("R4", c_so, 0);
            if (nd == 4) check("R5", c_car + c_so, 2);
            c_si = 1'b1;
            #1;
            check("R2", c_sum + 2 * (c_car + c_so), nd + 1);
            check("R3", c_sum, (nd + 1) % 2);
            check("R4", c_so, so0);
            if (nd == 4) check("R5", c_car + c_so, 2);
        end

        // ---- reset state: R8 ----
        a_i = 8'd200;
        b_i = 8'd150;
        repeat (3) @(negedge clk);
        check("R8", prod_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", prod_o, 200 * 150);

        // ---- latency: R7 ----
        a_i = 8'd7;
        b_i = 8'd9;
        #1;
        check("R7", prod_o, 200 * 150);
        @(negedge clk);
        check("R7", prod_o, 63);

        // ---- zero and one-hot operands: R6 ----
        apply(0, 173);
        check("R6", prod_o, 0);
        apply(211, 0);
        check("R6", prod_o, 0);
        for (int k = 0; k < W; k++) begin
            apply(1 << k, 181);
            check("R6", prod_o, 181 << k);
            apply(93, 1 << k);
            check("R6", prod_o, 93 << k);
        end

        // ---- largest operands: R9 ----
        apply(255, 255);
        check("R9", prod_o, 65025);

        // ---- asynchronous reset mid-cycle: R8 ----
        #2;
        rst_n = 1'b0;
        #1;
        check("R8", prod_o, 0);
        @(negedge clk);
        check("R8", prod_o, 0);
        rst_n = 1'b1;

        // ---- exhaustive sweep: R1 ----
        for (int p = 0; p < 65536; p++) begin
            apply(p >> 8, p & 255);
            check("R1", prod_o, (p >> 8) * (p & 255));
        end

        finish_run();
    end
endmodule